// File: doc/BRIEF.md
# Continuous Downlink Burst Assembler

This block builds one 510-bit continuous downlink burst for a π/4-DQPSK transmitter, in which every two consecutive bits form one symbol. A single flag selects between the normal and the synchronization kind. On an accepted start the block captures its scrambled payload vectors and merges them with the fixed head and tail training, the mid or sync training and, for the synchronization kind, the frequency-correction field. Two phase-adjustment dibits are then derived from the accumulated π/4 phase of given symbol ranges of that same burst. The finished burst is shifted out one bit per cycle with valid and last strobes.

The control is a four-state machine. IDLE waits with `ready_o` high. An accepted start (IDLE→SUM) loads the assembled burst into a buffer. SUM walks symbols 8 to 249 one per cycle, adding each symbol's phase to the first or second sum (SUM→FILL after symbol 249). FILL writes both phase dibits into the buffer (FILL→SEND). SEND shifts out 510 bits and returns to IDLE after the last one (SEND→IDLE).

Top module: `cdb_assembler`

## Requirements
- R1: After reset `ready_o` is 1 and `valid_o`, `last_o` and `bit_o` are 0.
- R2: A start is accepted only in a cycle where `start_i` and `ready_o` are both 1. All payload inputs, `kind_i` and `two_chan_i` are sampled in that cycle only. Later input changes, and `start_i` pulses while busy, have no effect on the burst being built.
- R3: The cycle after acceptance `ready_o` drops. Exactly 243 cycles after the accepting edge, `valid_o` rises and stays high for 510 consecutive cycles. `last_o` is high only with the 510th bit. On the following cycle `ready_o` is 1 and `valid_o` is 0.
- R4: Bit order is fixed. Payload vector bit 0 is sent first within its field. A training pattern written as a string of 0/1 is sent left character first.
- R5: The normal kind (`kind_i`=0) sends fields in this order: q11..q22, phase dibit 1, block 1 (216), broadcast bits 0..13, mid training (22), broadcast bits 14..29, block 2 (216), phase dibit 2, q1..q10. Here q = 1011011100000110101101.
- R6: For the normal kind the mid training is 1101000011101001110100 when `two_chan_i`=0 and 0111101001000011011110 when `two_chan_i`=1.
- R7: The sync kind (`kind_i`=1) sends fields in this order: q11..q22, phase dibit 1, 80 frequency-correction bits, sync block (120), sync training 11000001100111001110100111000001100111, broadcast bits 0..29, block 2 (216), phase dibit 2, q1..q10. The correction field is ones in its first 8 and last 8 positions and zeros elsewhere. `two_chan_i` has no effect on this kind.
- R8: Symbol n (1-based) consists of burst bits 2n-2 (first) and 2n-1 (second). Its phase in units of π/4 is +1 for (0,0), -1 for (1,0), +3 for (0,1) and -3 for (1,1), written as (first, second). Dibit 1 sums symbols 8..122 (normal) or 8..108 (sync). Dibit 2 sums the following symbols up to 249.
- R9: Each phase dibit is formed as follows. Compute a = -(sum rem 8), using a remainder that truncates toward zero. Subtract 8 if a > 3, or add 8 if a < -3. The dibit sent as (first, second) is (1,1) for -3, (0,1) for -1, (0,0) for +1 and (1,0) for +3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to build a burst |
| kind_i | input | 1 | 0 normal, 1 synchronization |
| two_chan_i | input | 1 | Normal kind: selects second mid training |
| blk1_i | input | 216 | Normal block 1 payload |
| sblk_i | input | 120 | Sync block payload |
| bcast_i | input | 30 | Broadcast bits |
| blk2_i | input | 216 | Block 2 payload |
| ready_o | output | 1 | Idle, start may be accepted |
| bit_o | output | 1 | Serial burst bit |
| valid_o | output | 1 | `bit_o` carries a burst bit |
| last_o | output | 1 | Final bit of the burst |

## Verification
The bench drives all-zero payloads, all-one payloads and random payloads through both kinds. These give phase sums of both signs and remainders in every wrap band, so a design that truncated the remainder the wrong way or skipped the ±8 wrap would send a wrong dibit at bit 12 or 498. A sync burst with `two_chan_i` set catches a design that let the channel flag leak into the sync layout. Start pulses during SUM and SEND, together with scrambled inputs after acceptance, expose a design that re-armed or re-sampled while busy. A single-cycle error in the 243-cycle latency or in the placement of `last_o` fails the per-clock comparison.

// File: rtl/cdb_pkg.sv
`timescale 1ns/1ps
package cdb_pkg;
    localparam int BURST_LEN  = 510;
    localparam int IDX_W      = $clog2(BURST_LEN);
    localparam int BLK_LEN    = 216;
    localparam int SBLK_LEN   = 120;
    localparam int BC_LEN     = 30;
    localparam int BC_SPLIT   = 14;
    localparam int FC_LEN     = 80;
    localparam int FC_EDGE    = 8;
    localparam int TRN_LEN    = 22;
    localparam int YTRN_LEN   = 38;
    localparam int HEAD_LEN   = 12;
    localparam int TAIL_LEN   = TRN_LEN - HEAD_LEN;
    localparam int SUM_W      = 12;

    localparam int PH1_POS    = HEAD_LEN;
    localparam int BODY_POS   = PH1_POS + 2;
    localparam int N_BC1_POS  = BODY_POS + BLK_LEN;
    localparam int N_MID_POS  = N_BC1_POS + BC_SPLIT;
    localparam int N_BC2_POS  = N_MID_POS + TRN_LEN;
    localparam int BLK2_POS   = N_BC2_POS + (BC_LEN - BC_SPLIT);
    localparam int S_SBLK_POS = BODY_POS + FC_LEN;
    localparam int S_Y_POS    = S_SBLK_POS + SBLK_LEN;
    localparam int S_BC_POS   = S_Y_POS + YTRN_LEN;
    localparam int PH2_POS    = BLK2_POS + BLK_LEN;
    localparam int TAIL_POS   = PH2_POS + 2;

    localparam int SYM_FIRST  = 8;
    localparam int SYM_LAST   = PH2_POS / 2;
    localparam int SPLIT_NORM = N_MID_POS / 2;
    localparam int SPLIT_SYNC = (S_Y_POS + 2) / 2;

    // patterns written left character first = MSB
    localparam logic [TRN_LEN-1:0]  HEAD_TAIL_SEQ = 22'b1011011100000110101101;
    localparam logic [TRN_LEN-1:0]  MID_ONE_SEQ   = 22'b1101000011101001110100;
    localparam logic [TRN_LEN-1:0]  MID_TWO_SEQ   = 22'b0111101001000011011110;
    localparam logic [YTRN_LEN-1:0] SYNC_SEQ      = 38'b11000001100111001110100111000001100111;

    typedef enum logic [1:0] {ST_IDLE, ST_SUM, ST_FILL, ST_SEND} state_t;

    // dibit[0] = first bit, dibit[1] = second bit
    function automatic logic signed [3:0] sym_phase(input logic [1:0] dibit);
        logic signed [3:0] mag;
        mag = dibit[1] ? 4'sd3 : 4'sd1;
        return dibit[0] ? -mag : mag;
    endfunction

    // returns {first, second}
    function automatic logic [1:0] adj_code(input logic signed [SUM_W-1:0] s);
        int r;
        int a;
        r = int'(s) % 8;
        a = -r;
        if (a > 3)       a = a - 8;
        else if (a < -3) a = a + 8;
        case (a)
            -3:      return 2'b11;
            -1:      return 2'b01;
            3:       return 2'b10;
            default: return 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/cdb_layout.sv
`timescale 1ns/1ps
module cdb_layout
    import cdb_pkg::*;
(
    input  logic                 kind,
    input  logic                 two_chan,
    input  logic [BLK_LEN-1:0]   blk1,
    input  logic [SBLK_LEN-1:0]  sblk,
    input  logic [BC_LEN-1:0]    bcast,
    input  logic [BLK_LEN-1:0]   blk2,
    output logic [BURST_LEN-1:0] burst
);
    logic [TRN_LEN-1:0] mid_seq;

    assign mid_seq = two_chan ? MID_TWO_SEQ : MID_ONE_SEQ;

    always_comb begin
        burst = '0;
        for (int i = 0; i < HEAD_LEN; i++)
            burst[i] = HEAD_TAIL_SEQ[TRN_LEN-1-TAIL_LEN-i];
        for (int i = 0; i < TAIL_LEN; i++)
            burst[TAIL_POS+i] = HEAD_TAIL_SEQ[TRN_LEN-1-i];
        for (int i = 0; i < BLK_LEN; i++)
            burst[BLK2_POS+i] = blk2[i];
        if (kind) begin
            for (int i = 0; i < FC_LEN; i++)
                burst[BODY_POS+i] = (i < FC_EDGE) || (i >= FC_LEN - FC_EDGE);
            for (int i = 0; i < SBLK_LEN; i++)
                burst[S_SBLK_POS+i] = sblk[i];
            for (int i = 0; i < YTRN_LEN; i++)
                burst[S_Y_POS+i] = SYNC_SEQ[YTRN_LEN-1-i];
            for (int i = 0; i < BC_LEN; i++)
                burst[S_BC_POS+i] = bcast[i];
        end else begin
            for (int i = 0; i < BLK_LEN; i++)
                burst[BODY_POS+i] = blk1[i];
            for (int i = 0; i < BC_SPLIT; i++)
                burst[N_BC1_POS+i] = bcast[i];
            for (int i = 0; i < TRN_LEN; i++)
                burst[N_MID_POS+i] = mid_seq[TRN_LEN-1-i];
            for (int i = 0; i < BC_LEN - BC_SPLIT; i++)
                burst[N_BC2_POS+i] = bcast[BC_SPLIT+i];
        end
    end
endmodule

// File: rtl/cdb_phase_accum.sv
`timescale 1ns/1ps
module cdb_phase_accum
    import cdb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    en,
    input  logic                    to_second,
    input  logic [1:0]              dibit,
    output logic signed [SUM_W-1:0] sum_first,
    output logic signed [SUM_W-1:0] sum_second
);
    logic signed [SUM_W-1:0] step;

    assign step = SUM_W'(sym_phase(dibit));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_first  <= '0;
            sum_second <= '0;
        end else if (clear) begin
            sum_first  <= '0;
            sum_second <= '0;
        end else if (en) begin
            if (to_second) sum_second <= sum_second + step;
            else           sum_first  <= sum_first + step;
        end
    end

    // R8
    first_range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clear && !to_second |=> sum_second == $past(sum_second));

    // R8
    second_range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clear && to_second |=> sum_first == $past(sum_first));
endmodule

// File: rtl/cdb_phase_map.sv
`timescale 1ns/1ps
module cdb_phase_map
    import cdb_pkg::*;
(
    input  logic signed [SUM_W-1:0] sum,
    output logic                    first_bit,
    output logic                    second_bit
);
    logic [1:0] code;

    assign code       = adj_code(sum);
    assign first_bit  = code[1];
    assign second_bit = code[0];
endmodule

// File: rtl/cdb_assembler.sv
`timescale 1ns/1ps
module cdb_assembler
    import cdb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                kind_i,
    input  logic                two_chan_i,
    input  logic [BLK_LEN-1:0]  blk1_i,
    input  logic [SBLK_LEN-1:0] sblk_i,
    input  logic [BC_LEN-1:0]   bcast_i,
    input  logic [BLK_LEN-1:0]  blk2_i,
    output logic                ready_o,
    output logic                bit_o,
    output logic                valid_o,
    output logic                last_o
);
    state_t                  state_q, state_d;
    logic [BURST_LEN-1:0]    buf_q;
    logic [BURST_LEN-1:0]    assembled;
    logic [IDX_W-1:0]        sym_q;
    logic [IDX_W-1:0]        sym_base;
    logic [IDX_W-1:0]        bit_q;
    logic                    kind_q;
    logic                    accept;
    logic                    in_second;
    logic [1:0]              sym_dibit;
    logic signed [SUM_W-1:0] sum_a, sum_b;
    logic signed [SUM_W-1:0] sums [2];
    logic [1:0]              ph_first, ph_second;

    assign accept    = start_i && (state_q == ST_IDLE);
    assign sym_base  = {sym_q[IDX_W-2:0], 1'b0} - IDX_W'(2);
    assign sym_dibit = buf_q[sym_base +: 2];
    assign in_second = kind_q ? (sym_q > IDX_W'(SPLIT_SYNC)) : (sym_q > IDX_W'(SPLIT_NORM));

    cdb_layout u_layout (
        .kind     (kind_i),
        .two_chan (two_chan_i),
        .blk1     (blk1_i),
        .sblk     (sblk_i),
        .bcast    (bcast_i),
        .blk2     (blk2_i),
        .burst    (assembled)
    );

    cdb_phase_accum u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .en         (state_q == ST_SUM),
        .to_second  (in_second),
        .dibit      (sym_dibit),
        .sum_first  (sum_a),
        .sum_second (sum_b)
    );

    assign sums[0] = sum_a;
    assign sums[1] = sum_b;

    for (genvar g = 0; g < 2; g++) begin : g_pmap
        cdb_phase_map u_map (
            .sum        (sums[g]),
            .first_bit  (ph_first[g]),
            .second_bit (ph_second[g])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SUM;
            ST_SUM:  if (sym_q == IDX_W'(SYM_LAST)) state_d = ST_FILL;
            ST_FILL: state_d = ST_SEND;
            ST_SEND: if (bit_q == IDX_W'(BURST_LEN-1)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            sym_q  <= '0;
            bit_q  <= '0;
            kind_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    buf_q  <= assembled;
                    kind_q <= kind_i;
                    sym_q  <= IDX_W'(SYM_FIRST);
                end
                ST_SUM:  sym_q <= sym_q + 1'b1;
                ST_FILL: begin
                    buf_q[PH1_POS]   <= ph_first[0];
                    buf_q[PH1_POS+1] <= ph_second[0];
                    buf_q[PH2_POS]   <= ph_first[1];
                    buf_q[PH2_POS+1] <= ph_second[1];
                    bit_q            <= '0;
                end
                ST_SEND: begin
                    buf_q <= buf_q >> 1;
                    bit_q <= bit_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ready_o = (state_q == ST_IDLE);
        valid_o = (state_q == ST_SEND);
        last_o  = (state_q == ST_SEND) && (bit_q == IDX_W'(BURST_LEN-1));
        bit_o   = (state_q == ST_SEND) && buf_q[0];
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && ready_o |=> !ready_o && !valid_o);

    // R3
    stream_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o |=> valid_o);

    // R3
    end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> ready_o && !valid_o);

    // R3
    stream_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> !last_o && $past(!ready_o));
endmodule

// File: tb/cdb_assembler_test.sv
`timescale 1ns/1ps
module cdb_assembler_test;
    localparam int BL = 510;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0, kind_i = 1'b0, two_chan_i = 1'b0;
    logic [215:0] blk1_i = '0, blk2_i = '0;
    logic [119:0] sblk_i = '0;
    logic [29:0]  bcast_i = '0;
    logic         ready_o, bit_o, valid_o, last_o;

    int checks = 0;
    int errors = 0;
    int wp;
    bit ref_bits [BL];

    always #2.5 clk = ~clk;

    cdb_assembler uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .two_chan_i(two_chan_i), .blk1_i(blk1_i), .sblk_i(sblk_i),
        .bcast_i(bcast_i), .blk2_i(blk2_i), .ready_o(ready_o),
        .bit_o(bit_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put_str(input string s);
        for (int i = 0; i < s.len(); i++) begin
            ref_bits[wp] = (s[i] == "1");
            wp++;
        end
    endtask

    function automatic int range_sum(input int lo, input int hi);
        int s = 0;
        for (int n = lo; n <= hi; n++) begin
            int f = ref_bits[2*n-2];
            int t = ref_bits[2*n-1];
            int mag = t ? 3 : 1;
            s += f ? -mag : mag;
        end
        return s;
    endfunction

    task automatic put_adj(input int pos, input int s);
        int a = -(s % 8);
        if (a > 3) a -= 8;
        else if (a < -3) a += 8;
        ref_bits[pos]   = (a == -3) || (a == 3);
        ref_bits[pos+1] = (a == -3) || (a == -1);
    endtask

    // R5 R6 R7 R8 R9 reference burst
    task automatic build_ref(input bit kind, input bit two);
        int split;
        wp = 0;
        put_str("000110101101");
        wp += 2;
        if (!kind) begin
            for (int i = 0; i < 216; i++) begin ref_bits[wp] = blk1_i[i]; wp++; end
            for (int i = 0; i < 14; i++) begin ref_bits[wp] = bcast_i[i]; wp++; end
            if (two) put_str("0111101001000011011110");
            else     put_str("1101000011101001110100");
            for (int i = 14; i < 30; i++) begin ref_bits[wp] = bcast_i[i]; wp++; end
            split = 122;
        end else begin
            for (int i = 0; i < 80; i++) begin ref_bits[wp] = (i < 8) || (i >= 72); wp++; end
            for (int i = 0; i < 120; i++) begin ref_bits[wp] = sblk_i[i]; wp++; end
            put_str("11000001100111001110100111000001100111");
            for (int i = 0; i < 30; i++) begin ref_bits[wp] = bcast_i[i]; wp++; end
            split = 108;
        end
        for (int i = 0; i < 216; i++) begin ref_bits[wp] = blk2_i[i]; wp++; end
        wp += 2;
        put_str("1011011100");
        ref_bits[12] = 0; ref_bits[13] = 0; ref_bits[498] = 0; ref_bits[499] = 0;
        put_adj(12, range_sum(8, split));
        put_adj(498, range_sum(split + 1, 249));
    endtask

    task automatic scramble_inputs();
        for (int i = 0; i < 216; i++) begin blk1_i[i] = $urandom; blk2_i[i] = $urandom; end
        for (int i = 0; i < 120; i++) sblk_i[i] = $urandom;
        for (int i = 0; i < 30; i++) bcast_i[i] = $urandom;
        kind_i = $urandom; two_chan_i = $urandom;
    endtask

    task automatic run_burst(input bit kind, input bit two, input int fill, input bit poke);
        @(negedge clk);
        if (fill == 0) begin blk1_i = '0; blk2_i = '0; sblk_i = '0; bcast_i = '0; end
        else if (fill == 1) begin blk1_i = '1; blk2_i = '1; sblk_i = '1; bcast_i = '1; end
        else scramble_inputs();
        kind_i = kind; two_chan_i = two;
        build_ref(kind, two);
        chk(ready_o == 1'b1, "R2 ready before start", ready_o, 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        scramble_inputs();
        for (int c = 0; c < 243; c++) begin
            chk(!valid_o && !ready_o, "R3 busy before stream", {ready_o, valid_o}, 0);
            start_i = poke && (c == 100);
            @(negedge clk);
        end
        start_i = 1'b0;
        for (int b = 0; b < BL; b++) begin
            chk(valid_o == 1'b1, "R3 valid", valid_o, 1);
            chk(last_o == (b == BL - 1), "R3 last", last_o, b == BL - 1);
            chk(bit_o == ref_bits[b], (kind ? "R7 R8 R9 sync bit" : "R5 R6 R8 R9 normal bit"),
                bit_o, ref_bits[b]);
            start_i = poke && (b == 200);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(ready_o && !valid_o, "R3 idle after last", {ready_o, valid_o}, 2);
        @(negedge clk);
        chk(!valid_o && ready_o, "R2 no burst from busy start", {ready_o, valid_o}, 2);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(ready_o == 1'b1, "R1 ready in reset", ready_o, 1);
        chk(!valid_o && !last_o && !bit_o, "R1 outputs low", {valid_o, last_o, bit_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o && !valid_o, "R1 after reset", {ready_o, valid_o}, 2);
        run_burst(1'b0, 1'b0, 0, 1'b0);  // R5 R6 one channel, zero payload
        run_burst(1'b0, 1'b1, 2, 1'b1);  // R6 two channels, random, busy pokes (R2)
        run_burst(1'b0, 1'b0, 1, 1'b0);  // R4 R9 all ones
        run_burst(1'b1, 1'b0, 0, 1'b0);  // R7 sync, zero payload
        run_burst(1'b1, 1'b1, 2, 1'b1);  // R7 two_chan ignored for sync
        run_burst(1'b1, 1'b0, 1, 1'b0);  // R8 R9 sync all ones
        for (int k = 0; k < 4; k++) run_burst(k[0], k[1], 2, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule